// File: doc/BRIEF.md
# Command Register with Parameter Collector

This block sits behind the write port of an adapter's control registers. Software first writes a command code to the command register. It then writes the parameters for that command, one 32-bit word at a time, to the data register. The block keeps a table of how many parameter words each command needs. As soon as that many words have arrived, it fires the command: it presents the command code and the collected words to the handlers for one cycle and latches the handler's result into a command status word that software can read.

Commands that take no parameters fire in the cycle right after the command write. An undefined code is replaced by a default command. The default command needs no parameters and always reports failure. After a command fires, the block returns to that default. A stray data word written with no command pending therefore runs the default command, which fails.

The handler logic inside the block computes the result of each command. It also keeps two readiness flags, one for the data rings and one for the message ring, so that it can apply the rule that the message ring may only be set up after the data rings. What a ring setup contains, and the resets of the attached devices, are left to the logic that consumes the fire pulse.

Top module: `cmd_param_collector`

## Requirements
- R1: After reset, `cmd_status` is 0 (success), `fire` is low, and `rings_ready` and `msgring_ready` are both low.
- R2: A command write latches a code in 1..9. Any other 32-bit value (0, 10 and above) selects the default command, code 0. Code 0 fires at once with `fire_cmd` = 0 and status 1 (failure).
- R3: A command write resets the word counter to zero. If the command needs parameters, `cmd_status` reads 2 (waiting for data) and `fire` stays low from the following cycle until enough words have arrived.
- R4: Commands that need no words fire in the cycle after the command write itself. These are 0 (default), 1 (adapter reset), 2 (bus reset), 8 (issue, not supported) and 9 (unplug, not supported).
- R5: Each data write stores its word at the counter position and advances the counter. After the write that brings the count up to the required number, `fire` is high for one cycle. Word k is then visible at `fire_params[32k+31:32k]`.
- R6: When a command fires, `cmd_status` takes the handler result in the same cycle, and the block returns to the default command with the counter at zero. A further data write therefore fires command 0 with status 1.
- R7: The required word counts are: 3 for device reset (code 3), 4 for abort (code 4), 6 for configuration (code 5), 10 for ring setup (code 6) and 2 for message-ring setup (code 7).
- R8: Codes 0, 5, 8 and 9 report failure (1). Codes 1, 2, 3, 4, 6 and 7 report success (0).
- R9: A ring setup (code 6) sets `rings_ready`. A message-ring setup (code 7) sets `msgring_ready` only if `rings_ready` is already set. An adapter reset (code 1) clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_is_data | input | 1 | 0 selects the command register, 1 the data register |
| wr_data | input | 32 | Write data |
| cmd_status | output | 32 | Command status: 0 success, 1 failure, 2 waiting for data |
| fire | output | 1 | One-cycle pulse when a command executes |
| fire_cmd | output | 4 | Code of the command executing |
| fire_params | output | 320 | Collected parameter words, word k at bits 32k+31:32k |
| rings_ready | output | 1 | Data rings have been set up |
| msgring_ready | output | 1 | Message ring has been set up |

## Verification
On every cycle, the embedded assertions check the following. A zero-word command write is followed by a fire. A command that needs parameters leaves the status at "waiting" with no fire. No fire ever reports the waiting code or an out-of-range command. The word counter never passes the buffer depth. The message-ring flag never rises without the data-ring flag. Only the bench scenarios show the rest: the per-command word counts and results, the contents of the parameter words, a command that is rewritten partway through collection, the drop back to the default command after a fire, and the clearing of both flags by an adapter reset.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  typedef enum logic [3:0] {
    CMD_NONE       = 4'd0,
    CMD_ADP_RST    = 4'd1,
    CMD_BUS_RST    = 4'd2,
    CMD_DEV_RST    = 4'd3,
    CMD_ABORT      = 4'd4,
    CMD_CONFIG     = 4'd5,
    CMD_RING_SETUP = 4'd6,
    CMD_MSG_SETUP  = 4'd7,
    CMD_SCSI_ISSUE = 4'd8,
    CMD_UNPLUG     = 4'd9,
    CMD_LIMIT      = 4'd10
  } cmd_e;

  localparam logic [31:0] ST_OK      = 32'd0;
  localparam logic [31:0] ST_FAIL    = 32'd1;
  localparam logic [31:0] ST_PENDING = 32'd2;

endpackage

// File: rtl/cpc_decode.sv
module cpc_decode
  import cpc_pkg::*;
#(
  parameter int CW         = 4,
  parameter int DEV_WORDS  = 3,
  parameter int ABT_WORDS  = 4,
  parameter int CFG_WORDS  = 6,
  parameter int RING_WORDS = 10,
  parameter int MSG_WORDS  = 2
) (
  input  logic [31:0]   raw_id,
  input  cmd_e          cur_cmd,
  output cmd_e          new_cmd,
  output logic [CW-1:0] new_words,
  output logic [CW-1:0] cur_words
);

  function automatic logic [CW-1:0] words_of(input cmd_e c);
    case (c)
      CMD_DEV_RST:    words_of = CW'(DEV_WORDS);
      CMD_ABORT:      words_of = CW'(ABT_WORDS);
      CMD_CONFIG:     words_of = CW'(CFG_WORDS);
      CMD_RING_SETUP: words_of = CW'(RING_WORDS);
      CMD_MSG_SETUP:  words_of = CW'(MSG_WORDS);
      default:        words_of = '0;
    endcase
  endfunction

  always_comb begin
    if ((raw_id > 32'd0) && (raw_id < 32'(CMD_LIMIT))) new_cmd = cmd_e'(raw_id[3:0]);
    else                                                new_cmd = CMD_NONE;
  end

  assign new_words = words_of(new_cmd);
  assign cur_words = words_of(cur_cmd);

endmodule

// File: rtl/cpc_param_buf.sv
module cpc_param_buf #(
  parameter int DEPTH = 10,
  parameter int CW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                push,
  input  logic [31:0]         din,
  output logic [CW-1:0]       count,
  output logic                full,
  output logic [DEPTH*32-1:0] words
);

  logic [CW-1:0] count_q, count_n;

  always_comb begin
    count_n = count_q;
    if (clr)       count_n = '0;
    else if (push) count_n = count_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_n;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic        slot_en;
    logic [31:0] slot_q;
    assign slot_en = push && (count_q == CW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= din;
    end
    assign words[32*i +: 32] = slot_q;
  end

  assign count = count_q;
  assign full  = (count_q == CW'(DEPTH));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

endmodule

// File: rtl/cpc_handlers.sv
module cpc_handlers
  import cpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec,
  input  cmd_e        exec_cmd,
  output logic [31:0] result,
  output logic        rings_ready,
  output logic        msgring_ready
);

  logic rings_q, rings_n, msg_q, msg_n;

  always_comb begin
    case (exec_cmd)
      CMD_ADP_RST, CMD_BUS_RST, CMD_DEV_RST, CMD_ABORT,
      CMD_RING_SETUP, CMD_MSG_SETUP: result = ST_OK;
      default:                       result = ST_FAIL;
    endcase
  end

  always_comb begin
    rings_n = rings_q;
    msg_n   = msg_q;
    if (exec) begin
      case (exec_cmd)
        CMD_RING_SETUP: rings_n = 1'b1;
        CMD_MSG_SETUP:  if (rings_q) msg_n = 1'b1;
        CMD_ADP_RST: begin
          rings_n = 1'b0;
          msg_n   = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rings_q <= 1'b0;
      msg_q   <= 1'b0;
    end else begin
      rings_q <= rings_n;
      msg_q   <= msg_n;
    end
  end

  assign rings_ready   = rings_q;
  assign msgring_ready = msg_q;

  // R9
  msg_needs_rings_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_q) |-> rings_q);

endmodule

// File: rtl/cmd_param_collector.sv
module cmd_param_collector
  import cpc_pkg::*;
#(
  parameter int DEV_WORDS  = 3,
  parameter int ABT_WORDS  = 4,
  parameter int CFG_WORDS  = 6,
  parameter int RING_WORDS = 10,
  parameter int MSG_WORDS  = 2,
  localparam int DEPTH_A   = (DEV_WORDS > ABT_WORDS) ? DEV_WORDS : ABT_WORDS,
  localparam int DEPTH_B   = (CFG_WORDS > RING_WORDS) ? CFG_WORDS : RING_WORDS,
  localparam int DEPTH_C   = (DEPTH_A > DEPTH_B) ? DEPTH_A : DEPTH_B,
  localparam int DEPTH     = (DEPTH_C > MSG_WORDS) ? DEPTH_C : MSG_WORDS,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_is_data,
  input  logic [31:0]         wr_data,
  output logic [31:0]         cmd_status,
  output logic                fire,
  output logic [3:0]          fire_cmd,
  output logic [DEPTH*32-1:0] fire_params,
  output logic                rings_ready,
  output logic                msgring_ready
);

  cmd_e          cur_q, cur_n, new_cmd, exec_cmd;
  logic [CW-1:0] new_words, cur_words, count;
  logic [CW:0]   count_inc;
  logic          full, clr, push, exec;
  logic [31:0]   status_q, status_n, result;
  logic          fire_q;
  cmd_e          fire_cmd_q;

  cpc_decode #(
    .CW(CW), .DEV_WORDS(DEV_WORDS), .ABT_WORDS(ABT_WORDS),
    .CFG_WORDS(CFG_WORDS), .RING_WORDS(RING_WORDS), .MSG_WORDS(MSG_WORDS)
  ) u_decode (
    .raw_id(wr_data), .cur_cmd(cur_q), .new_cmd(new_cmd),
    .new_words(new_words), .cur_words(cur_words)
  );

  cpc_param_buf #(.DEPTH(DEPTH), .CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .din(wr_data),
    .count(count), .full(full), .words(fire_params)
  );

  cpc_handlers u_handlers (
    .clk(clk), .rst_n(rst_n), .exec(exec), .exec_cmd(exec_cmd),
    .result(result), .rings_ready(rings_ready), .msgring_ready(msgring_ready)
  );

  assign count_inc = {1'b0, count} + {{CW{1'b0}}, 1'b1};

  always_comb begin
    cur_n    = cur_q;
    status_n = status_q;
    exec     = 1'b0;
    exec_cmd = cur_q;
    clr      = 1'b0;
    push     = 1'b0;
    if (wr_en && !wr_is_data) begin
      clr = 1'b1;
      if (new_words == '0) begin
        exec     = 1'b1;
        exec_cmd = new_cmd;
        status_n = result;
        cur_n    = CMD_NONE;
      end else begin
        cur_n    = new_cmd;
        status_n = ST_PENDING;
      end
    end else if (wr_en && wr_is_data && !full) begin
      push = 1'b1;
      if (count_inc >= {1'b0, cur_words}) begin
        exec     = 1'b1;
        exec_cmd = cur_q;
        status_n = result;
        cur_n    = CMD_NONE;
        clr      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= CMD_NONE;
      status_q   <= ST_OK;
      fire_q     <= 1'b0;
      fire_cmd_q <= CMD_NONE;
    end else begin
      cur_q    <= cur_n;
      status_q <= status_n;
      fire_q   <= exec;
      if (exec) fire_cmd_q <= exec_cmd;
    end
  end

  assign cmd_status = status_q;
  assign fire       = fire_q;
  assign fire_cmd   = fire_cmd_q;

  // R4
  zero_word_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_is_data && wr_data == 32'd2) |=> (fire && fire_cmd == 4'd2));

  // R3
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_is_data && wr_data == 32'd5) |=> (cmd_status == ST_PENDING && !fire));

  // R6
  fire_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (cmd_status != ST_PENDING));

  // R2
  fire_id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (fire_cmd < 4'd10));

endmodule

// File: tb/cmd_param_collector_tb.sv
module cmd_param_collector_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_is_data = 1'b0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  cmd_status;
  logic         fire;
  logic [3:0]   fire_cmd;
  logic [319:0] fire_params;
  logic         rings_ready, msgring_ready;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] st;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  cmd_param_collector u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_data(wr_is_data),
    .wr_data(wr_data), .cmd_status(cmd_status), .fire(fire), .fire_cmd(fire_cmd),
    .fire_params(fire_params), .rings_ready(rings_ready), .msgring_ready(msgring_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit is_data, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_is_data = is_data; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic expect_fire(input logic [3:0] c, input logic [31:0] s);
    exp_q.push_back('{cmd: c, st: s});
  endtask

  task automatic queue_empty(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Monitor: compares every fire pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && fire) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected fire", {28'd0, fire_cmd}, 32'hFFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(fire_cmd == e.cmd, "R2/R7 fire_cmd", {28'd0, fire_cmd}, {28'd0, e.cmd});
        check(cmd_status == e.st, "R6/R8 status", cmd_status, e.st);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    check(cmd_status == 32'd0, "R1 status", cmd_status, 0);
    check(!fire, "R1 fire", fire, 0);
    check(!rings_ready && !msgring_ready, "R1 flags", {rings_ready, msgring_ready}, 0);

    // R2: invalid codes collapse to default
    expect_fire(4'd0, 32'd1); wr(1'b0, 32'd0);  queue_empty("R2 code 0");
    expect_fire(4'd0, 32'd1); wr(1'b0, 32'd10); queue_empty("R2 code 10");
    expect_fire(4'd0, 32'd1); wr(1'b0, 32'hDEAD_0003); queue_empty("R2 wide code");

    // R4: bus reset runs on the command write
    expect_fire(4'd2, 32'd0); wr(1'b0, 32'd2); queue_empty("R4 bus reset");

    // R3/R5/R7: configuration needs six words, fails (R8)
    wr(1'b0, 32'd5);
    check(cmd_status == 32'd2, "R3 pending", cmd_status, 2);
    for (int k = 0; k < 5; k++) wr(1'b1, 32'hC0DE_0000 + k);
    check(cmd_status == 32'd2, "R7 config still pending", cmd_status, 2);
    expect_fire(4'd5, 32'd1); wr(1'b1, 32'hC0DE_0005);
    queue_empty("R5 config fire");
    for (int k = 0; k < 6; k++)
      check(fire_params[32*k +: 32] == 32'hC0DE_0000 + k, "R5 param word",
            fire_params[32*k +: 32], 32'hC0DE_0000 + k);

    // R9: message ring before data rings does not take effect
    wr(1'b0, 32'd7); wr(1'b1, 32'h11);
    expect_fire(4'd7, 32'd0); wr(1'b1, 32'h22);
    queue_empty("R7 msg words");
    check(!msgring_ready, "R9 msg without rings", msgring_ready, 0);

    // R9/R7: ring setup with ten words
    wr(1'b0, 32'd6);
    for (int k = 0; k < 9; k++) wr(1'b1, 32'h600 + k);
    check(cmd_status == 32'd2 && !rings_ready, "R7 ring pending", cmd_status, 2);
    expect_fire(4'd6, 32'd0); wr(1'b1, 32'h609);
    check(rings_ready, "R9 rings ready", rings_ready, 1);
    wr(1'b0, 32'd7); wr(1'b1, 32'h1);
    expect_fire(4'd7, 32'd0); wr(1'b1, 32'h2);
    check(msgring_ready, "R9 msg ready", msgring_ready, 1);

    // R6: stray data word runs the default command
    expect_fire(4'd0, 32'd1); wr(1'b1, 32'h5555); queue_empty("R6 stray data");

    // R3: rewriting the command restarts collection
    wr(1'b0, 32'd5);
    for (int k = 0; k < 3; k++) wr(1'b1, 32'h70 + k);
    wr(1'b0, 32'd4);
    for (int k = 0; k < 3; k++) wr(1'b1, 32'h80 + k);
    check(cmd_status == 32'd2, "R3 restart pending", cmd_status, 2);
    expect_fire(4'd4, 32'd0); wr(1'b1, 32'h83);
    queue_empty("R3 abort fire");
    check(fire_params[0 +: 32] == 32'h80, "R3 restart word0", fire_params[0 +: 32], 32'h80);

    // R7/R8: device reset three words
    wr(1'b0, 32'd3); wr(1'b1, 32'h1); wr(1'b1, 32'h2);
    expect_fire(4'd3, 32'd0); wr(1'b1, 32'h3); queue_empty("R7 device reset");

    // R4/R8: unsupported zero-word commands fail
    expect_fire(4'd8, 32'd1); wr(1'b0, 32'd8); queue_empty("R8 issue");
    expect_fire(4'd9, 32'd1); wr(1'b0, 32'd9); queue_empty("R8 unplug");

    // R9: adapter reset clears flags
    expect_fire(4'd1, 32'd0); wr(1'b0, 32'd1);
    queue_empty("R4 adapter reset");
    check(!rings_ready && !msgring_ready, "R9 flags cleared",
          {rings_ready, msgring_ready}, 0);

    repeat (2) @(negedge clk);
    queue_empty("R5 final scoreboard");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule